// File: doc/BRIEF.md
# Boot Descriptor Loader

After reset this block gathers the identification values a device needs before it can enumerate with its built-in default descriptor. In its first cycle out of reset it samples a presence input for a serial configuration memory. If a memory is present, the block reads the memory's header one byte at a time through a request/acknowledge port and assembles a two-byte length field. If no memory is present, it waits for an external master to write a one-byte length, and then the payload bytes, to a single command register address. Writes from the master to any other address have no effect.

A length of exactly 6 selects default mode. The six bytes that follow are captured as three 16-bit identifiers: vendor, product and device. Each identifier arrives low byte first. A length from 0 to 500 other than 6 selects custom mode, and the payload bytes are passed on, one at a time, on a byte-valid output. A length above 500 latches an error and loading stops. When loading finishes, a one-cycle done strobe is raised once. After that the block holds its results until the next reset.

Top module: `boot_desc_loader`

## Requirements
- R1: While reset is applied, and in the first cycle after reset is released, `done`, `err`, `desc_valid` and `mem_req` are low and all three identifiers read zero.
- R2: `mem_present` is sampled once, in the first cycle after the synchronised reset release. When it is high, every byte comes from the memory port and host writes are ignored. When it is low, no memory request is ever issued.
- R3: A memory request keeps `mem_req` high and `mem_addr` stable until the cycle in which `mem_ack` is high, and `mem_data` is taken in that cycle. The addresses requested are 5, then 6, then one higher for each byte after that.
- R4: In memory mode the length is assembled as {byte at address 6, byte at address 5}, low byte first. In host mode the length is the single byte written, with a zero high byte.
- R5: A length of exactly 6 sets `default_mode` to 1. The next six bytes are taken, in order, as vendor low, vendor high, product low, product high, device low and device high.
- R6: A length from 0 to 500 other than 6 sets `default_mode` to 0. Each of the following length bytes appears on `desc_byte` with a one-cycle `desc_valid` pulse, in order, in the cycle after the byte is accepted. A length of 0 streams nothing.
- R7: `done` pulses high for exactly one cycle, in the cycle after the last payload byte is accepted. In custom mode it coincides with the last `desc_valid`; with a length of 0 it follows the length byte. It is raised only once per reset.
- R8: A length greater than 500 sets `err`, which stays high. `done` and `desc_valid` never assert, and no further memory request is issued.
- R9: In host mode, only writes to address 0x30 are accepted as length or payload bytes. Writes to any other address are ignored.
- R10: After `done`, the identifiers, `default_mode` and `err` stay constant, and no further input changes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_present | input | 1 | High when a configuration memory is fitted |
| mem_req | output | 1 | Memory byte read request, held until acknowledged |
| mem_addr | output | 16 | Byte address of the current request |
| mem_ack | input | 1 | One-cycle answer to a request |
| mem_data | input | 8 | Byte returned with `mem_ack` |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 8 | Host register address |
| host_data | input | 8 | Host write data |
| vendor_id | output | 16 | Captured vendor identifier |
| product_id | output | 16 | Captured product identifier |
| device_id | output | 16 | Captured device identifier |
| default_mode | output | 1 | 1 = default descriptor, 0 = custom |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | Length out of range |
| desc_valid | output | 1 | Custom descriptor byte valid |
| desc_byte | output | 8 | Custom descriptor byte |

## Verification
The assertions assume that the memory answers each request with exactly one `mem_ack` pulse, and never raises `mem_ack` while no request is pending. The bench's memory model keeps to this. It waits a fixed latency while `mem_req` is high, acknowledges once, and then stays idle for one cycle so that it does not answer the following request early. Host writes are single-cycle strobes driven on the falling edge. They start only after the reset synchroniser and the presence sample have settled, so every write lands in a defined state.

// File: rtl/boot_ld_pkg.sv
package boot_ld_pkg;

  typedef enum logic [2:0] {
    ST_PROBE,
    ST_LEN_LO,
    ST_LEN_HI,
    ST_IDS,
    ST_STREAM,
    ST_FIN,
    ST_FAULT
  } ld_state_e;

  localparam int unsigned ID_BYTES    = 6;
  localparam int unsigned DEFAULT_LEN = 6;

endpackage

// File: rtl/boot_rst_sync.sv
module boot_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/boot_byte_src.sv
module boot_byte_src #(
  parameter int unsigned MEM_AW   = 16,
  parameter int unsigned HOST_AW  = 8,
  parameter int unsigned CMD_ADDR = 'h30
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               want,
  input  logic               use_mem,
  input  logic [MEM_AW-1:0]  rd_addr,
  output logic               mem_req,
  output logic [MEM_AW-1:0]  mem_addr,
  input  logic               mem_ack,
  input  logic [7:0]         mem_data,
  input  logic               host_wr,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [7:0]         host_data,
  output logic               byte_vld,
  output logic [7:0]         byte_val
);

  localparam logic [HOST_AW-1:0] CMD = HOST_AW'(CMD_ADDR);

  logic host_hit;

  always_comb begin
    host_hit = host_wr && (host_addr == CMD);
    mem_req  = want && use_mem;
    mem_addr = rd_addr;
    if (use_mem) begin
      byte_vld = want && mem_ack;
      byte_val = mem_data;
    end else begin
      byte_vld = want && host_hit;
      byte_val = host_data;
    end
  end

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

endmodule

// File: rtl/boot_id_capture.sv
module boot_id_capture #(
  parameter int unsigned NBYTES = boot_ld_pkg::ID_BYTES
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cap_en,
  input  logic [2:0]  idx,
  input  logic [7:0]  byte_in,
  output logic [15:0] vendor_id,
  output logic [15:0] product_id,
  output logic [15:0] device_id
);

  logic [7:0] cap_bytes [NBYTES];

  for (genvar g = 0; g < NBYTES; g++) begin : g_slot
    logic [7:0] slot_q;
    logic       slot_en;
    assign slot_en = cap_en && (idx == 3'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= '0;
      else if (slot_en) slot_q <= byte_in;
    end
    assign cap_bytes[g] = slot_q;
  end

  assign vendor_id  = {cap_bytes[1], cap_bytes[0]};
  assign product_id = {cap_bytes[3], cap_bytes[2]};
  assign device_id  = {cap_bytes[5], cap_bytes[4]};

  // R5
  cap_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |-> (idx < 3'(NBYTES)));

endmodule

// File: rtl/boot_desc_loader.sv
module boot_desc_loader
  import boot_ld_pkg::*;
#(
  parameter int unsigned MEM_AW   = 16,
  parameter int unsigned HOST_AW  = 8,
  parameter int unsigned CMD_ADDR = 'h30,
  parameter int unsigned LEN_ADDR = 5,
  parameter int unsigned MAX_LEN  = 500
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mem_present,
  output logic               mem_req,
  output logic [MEM_AW-1:0]  mem_addr,
  input  logic               mem_ack,
  input  logic [7:0]         mem_data,
  input  logic               host_wr,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [7:0]         host_data,
  output logic [15:0]        vendor_id,
  output logic [15:0]        product_id,
  output logic [15:0]        device_id,
  output logic               default_mode,
  output logic               done,
  output logic               err,
  output logic               desc_valid,
  output logic [7:0]         desc_byte
);

  localparam int unsigned CNT_W = $clog2(MAX_LEN + 1);

  logic              rst_sync_n;
  ld_state_e         st_q, st_d;
  logic              use_mem_q, use_mem_d;
  logic [MEM_AW-1:0] rd_addr_q, rd_addr_d;
  logic [7:0]        len_lo_q, len_lo_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [2:0]        idx_q, idx_d;
  logic              dmode_q, dmode_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic              dv_q, dv_d;
  logic [7:0]        db_q, db_d;
  logic              want, src_vld, cap_en;
  logic [7:0]        src_byte;
  logic [15:0]       len_full;

  boot_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  boot_byte_src #(
    .MEM_AW   (MEM_AW),
    .HOST_AW  (HOST_AW),
    .CMD_ADDR (CMD_ADDR)
  ) i_src (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .want      (want),
    .use_mem   (use_mem_q),
    .rd_addr   (rd_addr_q),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .mem_data  (mem_data),
    .host_wr   (host_wr),
    .host_addr (host_addr),
    .host_data (host_data),
    .byte_vld  (src_vld),
    .byte_val  (src_byte)
  );

  boot_id_capture #(.NBYTES(ID_BYTES)) i_ids (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cap_en     (cap_en),
    .idx        (idx_q),
    .byte_in    (src_byte),
    .vendor_id  (vendor_id),
    .product_id (product_id),
    .device_id  (device_id)
  );

  assign want = (st_q == ST_LEN_LO) || (st_q == ST_LEN_HI) ||
                (st_q == ST_IDS)    || (st_q == ST_STREAM);

  // next-state logic
  always_comb begin
    st_d      = st_q;
    use_mem_d = use_mem_q;
    rd_addr_d = rd_addr_q;
    len_lo_d  = len_lo_q;
    cnt_d     = cnt_q;
    idx_d     = idx_q;
    dmode_d   = dmode_q;
    err_d     = err_q;
    done_d    = 1'b0;
    dv_d      = 1'b0;
    db_d      = db_q;
    cap_en    = 1'b0;
    len_full  = use_mem_q ? {src_byte, len_lo_q} : {8'h00, src_byte};

    unique case (st_q)
      ST_PROBE: begin
        use_mem_d = mem_present;
        rd_addr_d = MEM_AW'(LEN_ADDR);
        st_d      = ST_LEN_LO;
      end
      ST_LEN_LO, ST_LEN_HI: begin
        if (src_vld) begin
          rd_addr_d = rd_addr_q + 1'b1;
          if (st_q == ST_LEN_LO && use_mem_q) begin
            len_lo_d = src_byte;
            st_d     = ST_LEN_HI;
          end else if (len_full == 16'(DEFAULT_LEN)) begin
            dmode_d = 1'b1;
            idx_d   = '0;
            st_d    = ST_IDS;
          end else if (len_full > 16'(MAX_LEN)) begin
            err_d = 1'b1;
            st_d  = ST_FAULT;
          end else if (len_full == 16'd0) begin
            dmode_d = 1'b0;
            done_d  = 1'b1;
            st_d    = ST_FIN;
          end else begin
            dmode_d = 1'b0;
            cnt_d   = CNT_W'(len_full);
            st_d    = ST_STREAM;
          end
        end
      end
      ST_IDS: begin
        if (src_vld) begin
          cap_en    = 1'b1;
          idx_d     = idx_q + 1'b1;
          rd_addr_d = rd_addr_q + 1'b1;
          if (idx_q == 3'(ID_BYTES - 1)) begin
            done_d = 1'b1;
            st_d   = ST_FIN;
          end
        end
      end
      ST_STREAM: begin
        if (src_vld) begin
          dv_d      = 1'b1;
          db_d      = src_byte;
          cnt_d     = cnt_q - 1'b1;
          rd_addr_d = rd_addr_q + 1'b1;
          if (cnt_q == CNT_W'(1)) begin
            done_d = 1'b1;
            st_d   = ST_FIN;
          end
        end
      end
      default: ;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q      <= ST_PROBE;
      use_mem_q <= 1'b0;
      rd_addr_q <= '0;
      len_lo_q  <= '0;
      cnt_q     <= '0;
      idx_q     <= '0;
      dmode_q   <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      dv_q      <= 1'b0;
      db_q      <= '0;
    end else begin
      st_q      <= st_d;
      use_mem_q <= use_mem_d;
      rd_addr_q <= rd_addr_d;
      len_lo_q  <= len_lo_d;
      cnt_q     <= cnt_d;
      idx_q     <= idx_d;
      dmode_q   <= dmode_d;
      done_q    <= done_d;
      err_q     <= err_d;
      dv_q      <= dv_d;
      db_q      <= db_d;
    end
  end

  assign default_mode = dmode_q;
  assign done         = done_q;
  assign err          = err_q;
  assign desc_valid   = dv_q;
  assign desc_byte    = db_q;

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> !done);

  // R8
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err |-> (!done && !desc_valid && !mem_req));

  // R8
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err |=> err);

  // R6
  stream_custom_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    desc_valid |-> !default_mode);

  // R10
  fin_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st_q == ST_FIN) |=> ((st_q == ST_FIN) && $stable(vendor_id) &&
      $stable(product_id) && $stable(device_id) && $stable(default_mode)));

  // R2
  probe_once_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st_q != ST_PROBE) |=> $stable(use_mem_q));

  // R2
  host_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st_q != ST_PROBE && !use_mem_q) |-> !mem_req);

endmodule

// File: tb/test_boot_desc_loader.sv
module test_boot_desc_loader;

  localparam time CLK_PERIOD = 10ns;
  localparam int  MEM_LAT    = 1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mem_present;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_ack;
  logic [7:0]  mem_data;
  logic        host_wr;
  logic [7:0]  host_addr;
  logic [7:0]  host_data;
  logic [15:0] vendor_id, product_id, device_id;
  logic        default_mode, done, err, desc_valid;
  logic [7:0]  desc_byte;

  int vecs  = 0;
  int miss  = 0;

  logic [7:0] mem [0:1023];
  logic [7:0] cap [0:1023];
  int ncap, ndone, nack;
  int exp_addr, addr_bad;
  logic dv_at_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_desc_loader i_boot_desc_loader (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_present  (mem_present),
    .mem_req      (mem_req),
    .mem_addr     (mem_addr),
    .mem_ack      (mem_ack),
    .mem_data     (mem_data),
    .host_wr      (host_wr),
    .host_addr    (host_addr),
    .host_data    (host_data),
    .vendor_id    (vendor_id),
    .product_id   (product_id),
    .device_id    (device_id),
    .default_mode (default_mode),
    .done         (done),
    .err          (err),
    .desc_valid   (desc_valid),
    .desc_byte    (desc_byte)
  );

  function automatic logic [7:0] pat(int i);
    return 8'((i * 13) + 5);
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // memory responder and output monitor, both on the falling edge
  initial begin
    int wcnt;
    wcnt = 0;
    mem_ack = 1'b0;
    mem_data = '0;
    forever begin
      @(negedge clk);
      if (desc_valid) begin
        cap[ncap] = desc_byte;
        ncap++;
      end
      if (done) begin
        ndone++;
        dv_at_done = desc_valid;
      end
      if (mem_ack) begin
        mem_ack = 1'b0;
        wcnt = 0;
      end else if (mem_req && rst_n) begin
        if (wcnt == MEM_LAT) begin
          if (int'(mem_addr) != exp_addr) addr_bad++;
          exp_addr++;
          mem_ack  = 1'b1;
          mem_data = mem[mem_addr[9:0]];
          nack++;
          wcnt = 0;
        end else begin
          wcnt++;
        end
      end
    end
  end

  task automatic start(logic present);
    rst_n       = 1'b0;
    mem_present = present;
    host_wr     = 1'b0;
    host_addr   = '0;
    host_data   = '0;
    repeat (3) @(negedge clk);
    ncap = 0; ndone = 0; nack = 0; exp_addr = 5; addr_bad = 0; dv_at_done = 1'b0;
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic wait_end();
    for (int i = 0; i < 5000; i++) begin
      if (ndone != 0 || err) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic hwrite(logic [7:0] a, logic [7:0] d);
    host_wr = 1'b1; host_addr = a; host_data = d;
    @(negedge clk);
    host_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic fill_header(int len);
    for (int i = 0; i < 5; i++) mem[i] = 8'hE0 + 8'(i);
    mem[5] = 8'(len);
    mem[6] = 8'(len >> 8);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; mem_present = 1'b1; host_wr = 1'b0;
    host_addr = '0; host_data = '0;
    repeat (2) @(negedge clk);
    chk("R1", "done in reset", done, 0);
    chk("R1", "err in reset", err, 0);
    chk("R1", "desc_valid in reset", desc_valid, 0);
    chk("R1", "mem_req in reset", mem_req, 0);
    chk("R1", "ids in reset", {vendor_id, product_id}, 0);
    chk("R1", "device id in reset", device_id, 0);
  endtask

  task automatic t_mem_default();
    fill_header(6);
    mem[7] = 8'h47; mem[8] = 8'h05; mem[9] = 8'h02;
    mem[10] = 8'h10; mem[11] = 8'h01; mem[12] = 8'h00;
    start(1'b1);
    wait_end();
    chk("R5", "vendor id", vendor_id, 16'h0547);
    chk("R5", "product id", product_id, 16'h1002);
    chk("R5", "device id", device_id, 16'h0001);
    chk("R5", "default_mode", default_mode, 1);
    chk("R7", "done pulses", ndone, 1);
    chk("R3", "address sequence errors", addr_bad, 0);
    chk("R3", "bytes read", nack, 8);
    // R10 and R2: host writes after done, memory mode
    hwrite(8'h30, 8'h06);
    hwrite(8'h30, 8'hFF);
    repeat (10) @(negedge clk);
    chk("R10", "vendor id after done", vendor_id, 16'h0547);
    chk("R10", "done pulses after done", ndone, 1);
    chk("R10", "no reads after done", nack, 8);
  endtask

  task automatic t_mem_custom(int len, string req);
    fill_header(len);
    for (int i = 0; i < len; i++) mem[7 + i] = pat(i);
    start(1'b1);
    wait_end();
    chk(req, "stream length", ncap, len);
    for (int i = 0; i < len && i < ncap; i++)
      if (cap[i] !== pat(i)) chk("R6", $sformatf("byte %0d", i), cap[i], pat(i));
    vecs++;
    chk("R6", "default_mode custom", default_mode, 0);
    chk("R7", "done pulses", ndone, 1);
    chk("R7", "last valid with done", dv_at_done, (len > 0) ? 1 : 0);
    chk("R3", "address sequence errors", addr_bad, 0);
    chk("R8", "no err", err, 0);
  endtask

  task automatic t_mem_err();
    fill_header(501);
    start(1'b1);
    repeat (60) @(negedge clk);
    chk("R8", "err", err, 1);
    chk("R8", "done", ndone, 0);
    chk("R8", "streamed", ncap, 0);
    chk("R8", "mem_req after err", mem_req, 0);
    chk("R8", "reads", nack, 2);
  endtask

  task automatic t_host_default();
    start(1'b0);
    hwrite(8'h31, 8'h06);
    hwrite(8'h30, 8'h06);
    hwrite(8'h2F, 8'hAA);
    hwrite(8'h30, 8'h34);
    hwrite(8'h30, 8'h12);
    hwrite(8'hB0, 8'h55);
    hwrite(8'h30, 8'h78);
    hwrite(8'h30, 8'h56);
    hwrite(8'h30, 8'hBC);
    hwrite(8'h00, 8'h99);
    hwrite(8'h30, 8'h9A);
    repeat (3) @(negedge clk);
    chk("R9", "vendor id", vendor_id, 16'h1234);
    chk("R9", "product id", product_id, 16'h5678);
    chk("R5", "device id", device_id, 16'h9ABC);
    chk("R5", "default_mode", default_mode, 1);
    chk("R7", "done pulses", ndone, 1);
    chk("R2", "no memory reads", nack, 0);
    hwrite(8'h30, 8'h11);
    repeat (4) @(negedge clk);
    chk("R10", "vendor id after done", vendor_id, 16'h1234);
    chk("R10", "done pulses after done", ndone, 1);
  endtask

  task automatic t_host_custom();
    start(1'b0);
    hwrite(8'h30, 8'h03);
    hwrite(8'h30, 8'hA1);
    hwrite(8'h44, 8'hEE);
    hwrite(8'h30, 8'hA2);
    hwrite(8'h30, 8'hA3);
    repeat (3) @(negedge clk);
    chk("R4", "host length stream", ncap, 3);
    chk("R9", "stream bytes", {cap[0], cap[1], cap[2]}, 24'hA1A2A3);
    chk("R6", "default_mode", default_mode, 0);
    chk("R7", "done pulses", ndone, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miss++;
    $display("FAIL R7 watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    ncap = 0; ndone = 0; nack = 0; exp_addr = 5; addr_bad = 0; dv_at_done = 1'b0;
    t_reset();
    t_mem_default();
    t_mem_custom(10, "R6");
    t_mem_custom(0, "R6");
    t_mem_custom(262, "R4");
    t_mem_custom(500, "R8");
    t_mem_err();
    t_host_default();
    t_host_custom();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

endmodule